// File: doc/BRIEF.md
# Camera Pixel Word Packer

This block takes samples from a parallel camera data bus and packs them into 32-bit words for a downstream buffer. A sample is taken on every clock where capture is enabled and the pixel-valid input is high. A 2-bit mode input sets how many bus bits make up one sample. Narrow 8-bit samples go four to a word. Wider 10, 12 and 14 bit samples are zero-extended to a 16-bit halfword and go two to a word. In both cases the earliest sample sits in the lowest lane.

When a word is complete the block registers it on the output and raises a one-cycle word-valid strobe. A change of mode, or dropping the capture enable, throws away any partly filled word. The next word then starts again in the lowest lane. Sync decoding, cropping and buffer transfer are handled by neighbouring blocks.

Top module: `pixel_word_packer`

## Requirements
- R1: Mode code 2'b00 selects 8-bit samples, 2'b01 selects 10-bit, 2'b10 selects 12-bit and 2'b11 selects 14-bit.
- R2: In 8-bit mode only input bits 7:0 are used. Bits 13:8 of the bus have no effect on the packed word.
- R3: In 8-bit mode four captured samples make one word. The first sample goes to bits 7:0, then bits 15:8, then bits 23:16, and the fourth goes to bits 31:24.
- R4: In the 10, 12 and 14 bit modes two captured samples make one word. The first goes to bits 15:0 and the second to bits 31:16.
- R5: In a wide mode each halfword holds the sample in its low bits. Every halfword bit at or above the sample width (10, 12 or 14) reads zero, whatever the input bus carried there.
- R6: The word that a sample completes appears on `wordOut` the cycle after that sample is taken. In that same cycle `wordValid` is high for exactly one clock. `wordOut` then holds its value until the next word completes.
- R7: A clock with `pixValid` low captures nothing, and a partial word waits across such gaps.
- R8: A clock whose mode differs from the previous clock's mode discards the partial word. A sample taken in that clock becomes the first sample of a new word in the new mode.
- R9: While `captureEn` is low no sample is taken and no word is produced. Any partial word is discarded, so capture resumes in the lowest lane.
- R10: A low `rstN` sampled at a clock edge clears `wordOut` to zero, `wordValid` to zero and the partial word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rstN | input | 1 | Synchronous reset, active low |
| captureEn | input | 1 | Capture enable; low discards the partial word |
| modeSel | input | 2 | Sample width code (see R1) |
| pixValid | input | 1 | Bus carries a valid sample this clock |
| pixData | input | 14 | Parallel camera data bus |
| wordOut | output | 32 | Last completed packed word |
| wordValid | output | 1 | One-clock strobe marking a new word |

## Verification
A sample taken at rising edge k completes its word at that same edge. The result can therefore be seen on `wordOut` and `wordValid` after edge k and up to edge k+1; results due from the reset, enable and mode rules follow the same one-edge latency. The bench changes inputs five nanoseconds after each rising edge, so the next edge sees stable values. At that same point it compares the outputs against a model advanced by one capture per edge. This means every expected value is checked in the one cycle the requirements place it in. The bench sweeps all four modes with bus values that set the bits above each sample width. It also covers valid gaps, a mid-word mode switch, an enable drop and a mid-word reset.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  localparam int DATA_W  = 14;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 16;
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
  localparam int HALVES_PER_WORD = WORD_W / HALF_W;
  localparam int SLOT_W  = $clog2(BYTES_PER_WORD);

  localparam logic [1:0] MODE_8  = 2'b00;
  localparam logic [1:0] MODE_10 = 2'b01;
  localparam logic [1:0] MODE_12 = 2'b10;
  localparam logic [1:0] MODE_14 = 2'b11;

  typedef struct packed {
    logic              load;
    logic [SLOT_W-1:0] slot;
    logic              emit;
  } pwpStrobe_t;

  function automatic logic [HALF_W-1:0] sampleMask(input logic [1:0] mode);
    case (mode)
      MODE_10: return 16'h03FF;
      MODE_12: return 16'h0FFF;
      MODE_14: return 16'h3FFF;
      default: return 16'h00FF;
    endcase
  endfunction
endpackage

// File: rtl/pwp_control.sv
module pwp_control
  import pwp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       captureEn,
  input  logic [1:0] modeSel,
  input  logic       pixValid,
  output pwpStrobe_t strobe
);
  logic [1:0]        modeQ;
  logic [SLOT_W-1:0] cntQ, cntNext, effCnt, lastSlot;
  logic              capture, modeChange;

  always_comb begin
    capture    = captureEn & pixValid;
    modeChange = (modeSel != modeQ);
    effCnt     = modeChange ? '0 : cntQ;
    lastSlot   = (modeSel == MODE_8) ? SLOT_W'(BYTES_PER_WORD - 1)
                                     : SLOT_W'(HALVES_PER_WORD - 1);
    strobe.load = capture;
    strobe.slot = effCnt;
    strobe.emit = capture && (effCnt == lastSlot);
    if (!captureEn)       cntNext = '0;
    else if (capture)     cntNext = strobe.emit ? '0 : effCnt + 1'b1;
    else                  cntNext = effCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_8;
      cntQ  <= '0;
    end else begin
      modeQ <= modeSel;
      cntQ  <= cntNext;
    end
  end
endmodule

// File: rtl/pwp_datapath.sv
module pwp_datapath
  import pwp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pwpStrobe_t        strobe,
  input  logic [1:0]        modeSel,
  input  logic [DATA_W-1:0] pixData,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  logic [WORD_W-1:0] accQ, accNext, outQ;
  logic              validQ;
  logic [HALF_W-1:0] halfSample;
  logic [BYTE_W-1:0] byteSample;
  logic [WORD_W-1:0] byteLane [BYTES_PER_WORD];
  logic [WORD_W-1:0] halfLane [HALVES_PER_WORD];

  assign byteSample = pixData[BYTE_W-1:0];
  assign halfSample = HALF_W'(pixData) & sampleMask(modeSel);

  for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : gByte
    always_comb begin
      byteLane[g] = (g == 0) ? '0 : accQ;
      byteLane[g][g*BYTE_W +: BYTE_W] = byteSample;
    end
  end

  for (genvar h = 0; h < HALVES_PER_WORD; h++) begin : gHalf
    always_comb begin
      halfLane[h] = (h == 0) ? '0 : accQ;
      halfLane[h][h*HALF_W +: HALF_W] = halfSample;
    end
  end

  always_comb begin
    if (modeSel == MODE_8) accNext = byteLane[strobe.slot];
    else                   accNext = halfLane[strobe.slot[0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      outQ   <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobe.load & strobe.emit;
      if (strobe.load) accQ <= accNext;
      if (strobe.load && strobe.emit) outQ <= accNext;
    end
  end

  assign wordOut   = outQ;
  assign wordValid = validQ;
endmodule

// File: rtl/pixel_word_packer.sv
module pixel_word_packer
  import pwp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              captureEn,
  input  logic [1:0]        modeSel,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  pwpStrobe_t strobe;

  pwp_control u_ctl (
    .clk(clk), .rstN(rstN), .captureEn(captureEn),
    .modeSel(modeSel), .pixValid(pixValid), .strobe(strobe)
  );

  pwp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeSel(modeSel),
    .pixData(pixData), .wordOut(wordOut), .wordValid(wordValid)
  );
endmodule

// File: rtl/pwp_checker.sv
module pwp_checker
  import pwp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              captureEn,
  input logic [1:0]        modeSel,
  input logic              pixValid,
  input logic [WORD_W-1:0] wordOut,
  input logic              wordValid
);
  // R6: a word strobe never lasts two clocks
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R7: a word only follows a clock in which a sample was taken
  p_needs_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(pixValid && captureEn));

  // R9: no word after a clock with capture disabled
  p_enable_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(captureEn) |-> !wordValid);

  // R5: padding bits above the sample width stay zero
  p_pad10_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && $past(modeSel) == MODE_10) |->
      (wordOut[15:10] == '0 && wordOut[31:26] == '0));
  p_pad12_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && $past(modeSel) == MODE_12) |->
      (wordOut[15:12] == '0 && wordOut[31:28] == '0));
  p_pad14_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && $past(modeSel) == MODE_14) |->
      (wordOut[15:14] == '0 && wordOut[31:30] == '0));
endmodule

bind pixel_word_packer pwp_checker u_chk (.*);

// File: tb/pixel_word_packer_test.sv
module pixel_word_packer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        captureEn = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic        pixValid = 1'b0;
  logic [13:0] pixData = '0;
  logic [31:0] wordOut;
  logic        wordValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model state
  int          mCnt = 0;
  logic [1:0]  mPrevMode = 2'b00;
  logic [31:0] mAcc = '0;
  logic [31:0] mWord = '0;
  logic        mValid = 1'b0;

  pixel_word_packer uut (
    .clk(clk), .rstN(rstN), .captureEn(captureEn), .modeSel(modeSel),
    .pixValid(pixValid), .pixData(pixData), .wordOut(wordOut), .wordValid(wordValid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance the model by one clock edge using the current inputs.
  task automatic modelStep();
    int width;
    logic [31:0] mask;
    mValid = 1'b0;
    if (!rstN) begin
      mCnt = 0; mAcc = '0; mWord = '0; mPrevMode = 2'b00;
      return;
    end
    if (!captureEn) mCnt = 0;
    else begin
      if (modeSel != mPrevMode) mCnt = 0;
      if (pixValid) begin
        if (mCnt == 0) mAcc = '0;
        width = 8 + 2 * int'(modeSel);           // R1 width per code
        mask = (32'h1 << width) - 1;
        if (modeSel == 2'b00) mAcc = mAcc | ((32'(pixData) & mask) << (8 * mCnt));
        else                  mAcc = mAcc | ((32'(pixData) & mask) << (16 * mCnt));
        mCnt++;
        if (mCnt == ((modeSel == 2'b00) ? 4 : 2)) begin
          mCnt = 0; mWord = mAcc; mValid = 1'b1;
        end
      end
    end
    mPrevMode = modeSel;
  endtask

  // Apply inputs, pass one edge, check outputs 5 ns after it.
  task automatic step(input string req, input logic en, input logic [1:0] mode,
                      input logic v, input logic [13:0] d);
    captureEn = en; modeSel = mode; pixValid = v; pixData = d;
    @(posedge clk);
    modelStep();
    #5;
    check({req, " valid"}, 32'(wordValid), 32'(mValid));  // R6 one-edge latency
    check({req, " word"}, wordOut, mWord);
  endtask

  initial begin
    // R10: reset state
    rstN = 1'b0;
    step("R10", 1'b1, 2'b00, 1'b1, 14'h3FFF);
    step("R10", 1'b1, 2'b00, 1'b1, 14'h3FFF);
    rstN = 1'b1;

    // R1 R2 R3 R4 R5: sweep every mode, high bus bits set
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 12; i++) begin
        step((m == 0) ? "R3" : "R4", 1'b1, 2'(m), 1'b1,
             14'((i * 16'h1357 + m * 16'h0ABC) | 16'h3F00));
      end
    end

    // R2: 8-bit mode, only high bits differ from a prior word
    for (int i = 0; i < 4; i++) step("R2", 1'b1, 2'b00, 1'b1, 14'(16'h2A00 | 16'(i)));
    for (int i = 0; i < 4; i++) step("R2", 1'b1, 2'b00, 1'b1, 14'(16'h1500 | 16'(i)));

    // R7: gaps in pixValid, every third clock idle
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 15; i++) begin
        step("R7", 1'b1, 2'(m), (i % 3) != 2, 14'(i * 16'h0777 + 16'h0123));
      end
    end

    // R8: mode switch mid-word
    step("R8", 1'b1, 2'b00, 1'b1, 14'h0011);
    step("R8", 1'b1, 2'b00, 1'b1, 14'h0022);
    step("R8", 1'b1, 2'b01, 1'b1, 14'h3333);
    step("R8", 1'b1, 2'b01, 1'b1, 14'h0044);
    step("R8", 1'b1, 2'b01, 1'b1, 14'h0055);
    step("R8", 1'b1, 2'b11, 1'b1, 14'h3FFF);
    step("R8", 1'b1, 2'b11, 1'b1, 14'h2001);
    step("R8", 1'b1, 2'b00, 1'b1, 14'h00AA);
    for (int i = 0; i < 4; i++) step("R8", 1'b1, 2'b00, 1'b1, 14'(16'h00B0 + 16'(i)));

    // R9: enable drop mid-word, samples while disabled ignored
    step("R9", 1'b1, 2'b00, 1'b1, 14'h00C1);
    step("R9", 1'b1, 2'b00, 1'b1, 14'h00C2);
    for (int i = 0; i < 5; i++) step("R9", 1'b0, 2'b00, 1'b1, 14'h00EE);
    for (int i = 0; i < 4; i++) step("R9", 1'b1, 2'b00, 1'b1, 14'(16'h00D0 + 16'(i)));
    step("R9", 1'b1, 2'b10, 1'b1, 14'h0F01);
    step("R9", 1'b0, 2'b10, 1'b1, 14'h0F02);
    step("R9", 1'b1, 2'b10, 1'b1, 14'h3F03);
    step("R9", 1'b1, 2'b10, 1'b1, 14'h3F04);

    // R10: reset mid-word clears output and partial word
    step("R10", 1'b1, 2'b00, 1'b1, 14'h0061);
    step("R10", 1'b1, 2'b00, 1'b1, 14'h0062);
    rstN = 1'b0;
    step("R10", 1'b1, 2'b00, 1'b1, 14'h0063);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) step("R10", 1'b1, 2'b00, 1'b1, 14'(16'h0070 + 16'(i)));
    step("R6", 1'b1, 2'b00, 1'b0, 14'h0000);
    step("R6", 1'b1, 2'b00, 1'b0, 14'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule